// File: doc/BRIEF.md
# Per-Line Sprite Evaluator

The block picks the sprites for the next display line. It reads a table of 64 four-byte sprite entries through a read port, one entry per clock. A single pulse of `start` begins a pass. This pulse would come from the raster counter at dot 257 of every visible line and of line 261. During a pass the block clears a working set of eight four-byte slots to 0xFF. It then walks the table in index order and copies each entry that covers the next line into the next free slot. Each slot is tagged when its source is table entry 0. A sprite that qualifies after all eight slots are full raises a sticky overflow flag, but only while sprite or background display is enabled.

The working set is published to a read-out bank once the scan has finished. The per-pixel logic reads slots through `rd_slot` for a whole line, and nothing that an evaluation pass does disturbs that bank. A slot whose four bytes are all 0xFF marks the end of the valid sprites. The overflow flag is cleared only by `clr_flags`, which the raster counter pulses at dot 1 of line 261.

Top module: `sprite_line_eval`

## Requirements
- R1: After reset, every published slot reads 0xFFFFFFFF, all eight sprite-0 tags are 0, and `overflow`, `busy` and `done` are 0.
- R2: A `start` sampled at clock edge E0 sets `busy` after E0, with `tab_addr` = 0. `tab_addr` then advances by one per clock through 63. `done` is high for exactly the one cycle after edge E0+65, and `busy` falls at that same edge.
- R3: Every slot not filled by the pass reads 0xFFFFFFFF after `done`.
- R4: An entry qualifies when top = Y + 1 satisfies top ≤ line + 1 ≤ top + height − 1 and top < 241. Y is bits 7:0 of `tab_entry`. The line and height are latched at `start`.
- R5: The first eight qualifying entries are copied, all 32 bits unchanged, into slots 0, 1, 2… in table order.
- R6: A slot's sprite-0 tag (`slot_zero_tags[k]` and `rd_zero`) is 1 exactly when that slot was filled from entry 0.
- R7: A qualifying entry found while all eight slots are full sets `overflow` when `show_spr` or `show_bg` was 1 at `start`. It does not set `overflow` when both were 0.
- R8: `overflow` stays set across later passes and is cleared one cycle after a `clr_flags` pulse. `clr_flags` wins over a simultaneous set.
- R9: The published slots and tags change only at the edge that raises `done`. They hold their values throughout a pass.
- R10: With `tall` = 1 the height is 16 lines. With `tall` = 0 it is 8.
- R11: A `start` during a pass restarts the scan from entry 0 with cleared slots. `done` then follows 65 edges after the new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins or restarts a pass |
| line | input | 9 | Current line number (0..261), latched at start |
| tall | input | 1 | 1 = 16-line sprites, 0 = 8-line sprites |
| show_spr | input | 1 | Sprite display enable |
| show_bg | input | 1 | Background display enable |
| clr_flags | input | 1 | Clears the overflow flag |
| tab_addr | output | 6 | Index of the table entry being examined |
| tab_entry | input | 32 | Entry at tab_addr, same cycle: Y in 7:0, tile 15:8, attributes 23:16, X 31:24 |
| rd_slot | input | 3 | Published slot to read |
| rd_entry | output | 32 | Contents of the selected published slot |
| rd_zero | output | 1 | Sprite-0 tag of the selected published slot |
| slot_zero_tags | output | 8 | Sprite-0 tags of all published slots |
| overflow | output | 1 | Sticky sprite overflow flag |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle pulse when the new slots are published |

## Verification
Every pass has fixed timing. `busy` and `tab_addr` = 0 are due one edge after the start edge. `done` is low after edge 64 and high after edge 65, and it falls after edge 66. The results appear only at edge 65. Overflow is cleared one edge after `clr_flags`. The bench drives every input on the falling edge and counts that many falling edges from the start before it samples. Slots and overflow are compared only after the `done` check, against a table model kept in the bench. The published slot 0 is also sampled at every falling edge of a pass, to show that it holds.

// File: rtl/sle_pkg.sv
`timescale 1ns/1ps
package sle_pkg;
  localparam int LINE_W   = 9;
  localparam int TOP_W    = LINE_W + 1;
  localparam int TOP_LIMIT = 241;
  localparam int ENTRY_W  = 32;
  localparam int Y_W      = 8;

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_PUB} sle_state_e;

  // Top-edge and next-line test of one entry: top = y+1, range [top, top+h-1].
  function automatic logic covers_next(input logic [Y_W-1:0] y,
                                       input logic [LINE_W-1:0] ln,
                                       input logic tall_m);
    logic [TOP_W-1:0] top, nxt, bot;
    top = {{(TOP_W-Y_W){1'b0}}, y} + TOP_W'(1);
    nxt = {1'b0, ln} + TOP_W'(1);
    bot = top + (tall_m ? TOP_W'(15) : TOP_W'(7));
    return (top <= nxt) && (nxt <= bot) && (top < TOP_W'(TOP_LIMIT));
  endfunction
endpackage

// File: rtl/sle_range.sv
`timescale 1ns/1ps
module sle_range
  import sle_pkg::*;
(
  input  logic [Y_W-1:0]    y_byte,
  input  logic [LINE_W-1:0] line_q,
  input  logic              tall_q,
  output logic              hit
);
  always_comb hit = covers_next(y_byte, line_q, tall_q);
endmodule

// File: rtl/sle_ctrl.sv
`timescale 1ns/1ps
module sle_ctrl
  import sle_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int SLOTS   = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [LINE_W-1:0]           line,
  input  logic                        tall,
  input  logic                        ovf_en,
  input  logic                        clr_flags,
  input  logic                        hit,
  output logic [$clog2(ENTRIES)-1:0]  idx,
  output logic [$clog2(SLOTS)-1:0]    wr_slot,
  output logic                        wr_en,
  output logic                        wr_zero,
  output logic                        clr_work,
  output logic                        pub_we,
  output logic [LINE_W-1:0]           line_q,
  output logic                        tall_q,
  output logic                        overflow,
  output logic                        busy,
  output logic                        done
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int CNT_W = $clog2(SLOTS + 1);
  localparam int SLOT_W = $clog2(SLOTS);

  sle_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_en_q, ovf_q, done_q;

  logic scan_act, room, last_idx, ovf_set;
  assign scan_act = (state_q == ST_SCAN);
  assign room     = (cnt_q < CNT_W'(SLOTS));
  assign last_idx = (idx_q == IDX_W'(ENTRIES - 1));
  assign wr_en    = scan_act && hit && room;
  assign ovf_set  = scan_act && hit && !room && ovf_en_q;
  assign wr_slot  = SLOT_W'(cnt_q);
  assign wr_zero  = (idx_q == '0);
  assign clr_work = start;
  assign pub_we   = (state_q == ST_PUB);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      cnt_q    <= '0;
      line_q   <= '0;
      tall_q   <= 1'b0;
      ovf_en_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= (state_q == ST_PUB);
      if (start) begin
        state_q  <= ST_SCAN;
        idx_q    <= '0;
        cnt_q    <= '0;
        line_q   <= line;
        tall_q   <= tall;
        ovf_en_q <= ovf_en;
      end else begin
        unique case (state_q)
          ST_SCAN: begin
            if (wr_en) cnt_q <= cnt_q + CNT_W'(1);
            if (last_idx) state_q <= ST_PUB;
            else          idx_q   <= idx_q + IDX_W'(1);
          end
          ST_PUB:  state_q <= ST_IDLE;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         ovf_q <= 1'b0;
    else if (clr_flags) ovf_q <= 1'b0;
    else if (ovf_set)   ovf_q <= 1'b1;
  end

  assign idx      = idx_q;
  assign overflow = ovf_q;
  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;

  p_walk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_act && !start && !last_idx) |=> (scan_act && idx_q == $past(idx_q) + IDX_W'(1)));
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_slot_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(SLOTS));
  p_ovf_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> $past(ovf_en_q));
  p_ovf_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_flags |=> !overflow);
  p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (scan_act && idx_q == '0 && cnt_q == '0));
endmodule

// File: rtl/sle_store.sv
`timescale 1ns/1ps
module sle_store
  import sle_pkg::*;
#(
  parameter int SLOTS = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr_work,
  input  logic                      wr_en,
  input  logic [$clog2(SLOTS)-1:0]  wr_slot,
  input  logic [ENTRY_W-1:0]        wr_data,
  input  logic                      wr_zero,
  input  logic                      pub_we,
  input  logic [$clog2(SLOTS)-1:0]  rd_slot,
  output logic [ENTRY_W-1:0]        rd_entry,
  output logic                      rd_zero,
  output logic [SLOTS-1:0]          pub_tags
);
  localparam int BANK_W = SLOTS * ENTRY_W;

  logic [BANK_W-1:0] work_q, pub_q;
  logic [SLOTS-1:0]  wtag_q, ptag_q;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n || clr_work) begin
        work_q[g*ENTRY_W +: ENTRY_W] <= '1;
        wtag_q[g]                    <= 1'b0;
      end else if (wr_en && wr_slot == g) begin
        work_q[g*ENTRY_W +: ENTRY_W] <= wr_data;
        wtag_q[g]                    <= wr_zero;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pub_q  <= '1;
      ptag_q <= '0;
    end else if (pub_we) begin
      pub_q  <= work_q;
      ptag_q <= wtag_q;
    end
  end

  assign rd_entry = pub_q[ENTRY_W*rd_slot +: ENTRY_W];
  assign rd_zero  = ptag_q[rd_slot];
  assign pub_tags = ptag_q;

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_work |=> (work_q == '1 && wtag_q == '0));
  p_pub_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pub_we |=> ($stable(pub_q) && $stable(ptag_q)));
endmodule

// File: rtl/sprite_line_eval.sv
`timescale 1ns/1ps
module sprite_line_eval
  import sle_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int SLOTS   = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [8:0]                  line,
  input  logic                        tall,
  input  logic                        show_spr,
  input  logic                        show_bg,
  input  logic                        clr_flags,
  output logic [$clog2(ENTRIES)-1:0]  tab_addr,
  input  logic [31:0]                 tab_entry,
  input  logic [$clog2(SLOTS)-1:0]    rd_slot,
  output logic [31:0]                 rd_entry,
  output logic                        rd_zero,
  output logic [SLOTS-1:0]            slot_zero_tags,
  output logic                        overflow,
  output logic                        busy,
  output logic                        done
);
  localparam int SLOT_W = $clog2(SLOTS);

  logic              hit, wr_en, wr_zero, clr_work, pub_we, tall_q;
  logic [SLOT_W-1:0] wr_slot;
  logic [LINE_W-1:0] line_q;

  sle_range u_range (
    .y_byte (tab_entry[Y_W-1:0]),
    .line_q (line_q),
    .tall_q (tall_q),
    .hit    (hit)
  );

  sle_ctrl #(.ENTRIES(ENTRIES), .SLOTS(SLOTS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .line      (line),
    .tall      (tall),
    .ovf_en    (show_spr | show_bg),
    .clr_flags (clr_flags),
    .hit       (hit),
    .idx       (tab_addr),
    .wr_slot   (wr_slot),
    .wr_en     (wr_en),
    .wr_zero   (wr_zero),
    .clr_work  (clr_work),
    .pub_we    (pub_we),
    .line_q    (line_q),
    .tall_q    (tall_q),
    .overflow  (overflow),
    .busy      (busy),
    .done      (done)
  );

  sle_store #(.SLOTS(SLOTS)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_work (clr_work),
    .wr_en    (wr_en),
    .wr_slot  (wr_slot),
    .wr_data  (tab_entry),
    .wr_zero  (wr_zero),
    .pub_we   (pub_we),
    .rd_slot  (rd_slot),
    .rd_entry (rd_entry),
    .rd_zero  (rd_zero),
    .pub_tags (slot_zero_tags)
  );

  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: tb/tb_sprite_line_eval.sv
`timescale 1ns/1ps
module tb_sprite_line_eval;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, tall = 1'b0, show_spr = 1'b0, show_bg = 1'b0, clr_flags = 1'b0;
  logic [8:0]  line = '0;
  logic [5:0]  tab_addr;
  logic [31:0] tab_entry, rd_entry;
  logic [2:0]  rd_slot = '0;
  logic        rd_zero, overflow, busy, done;
  logic [7:0]  slot_zero_tags;
  logic [31:0] tbl [64];
  int n_chk = 0, n_bad = 0;
  logic exp_ovf = 1'b0;

  always #10 clk = ~clk;
  assign tab_entry = tbl[tab_addr];

  sprite_line_eval dut (
    .clk(clk), .rst_n(rst_n), .start(start), .line(line), .tall(tall),
    .show_spr(show_spr), .show_bg(show_bg), .clr_flags(clr_flags),
    .tab_addr(tab_addr), .tab_entry(tab_entry), .rd_slot(rd_slot),
    .rd_entry(rd_entry), .rd_zero(rd_zero), .slot_zero_tags(slot_zero_tags),
    .overflow(overflow), .busy(busy), .done(done)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int i, input logic [7:0] y);
    return {8'(i), 8'(i) ^ 8'h5A, 8'(i + 3), y};
  endfunction

  task automatic fill_empty();
    for (int i = 0; i < 64; i++) tbl[i] = mk(i, 8'd200);
  endtask

  function automatic bit qual(input logic [7:0] y, input int ln, input bit t);
    int top = int'(y) + 1;
    int h = t ? 16 : 8;
    return (top <= ln + 1) && (ln + 1 <= top + h - 1) && (top < 241);
  endfunction

  task automatic pulse_clr();
    @(negedge clk); clr_flags = 1'b1;
    @(negedge clk); clr_flags = 1'b0;
    exp_ovf = 1'b0;
  endtask

  // Compare published slots, tags and overflow against the table model.
  task automatic check_result(input int ln, input bit t, input bit en, input string tag);
    logic [31:0] es [8];
    logic [7:0]  et = '0;
    int n = 0;
    for (int k = 0; k < 8; k++) es[k] = 32'hFFFF_FFFF;
    for (int i = 0; i < 64; i++) begin
      if (qual(tbl[i][7:0], ln, t)) begin
        if (n < 8) begin es[n] = tbl[i]; et[n] = (i == 0); n++; end
        else if (en) exp_ovf = 1'b1;
      end
    end
    for (int k = 0; k < 8; k++) begin
      rd_slot = 3'(k); #1;
      chk((es[k] == 32'hFFFF_FFFF) ? "R3" : "R5", {tag, " slot"}, rd_entry, es[k]);
      chk("R6", {tag, " rd_zero"}, 32'(rd_zero), 32'(et[k]));
    end
    rd_slot = '0;
    chk("R6", {tag, " tags"}, 32'(slot_zero_tags), 32'(et));
    chk("R7", {tag, " overflow"}, 32'(overflow), 32'(exp_ovf));
  endtask

  // One full pass with timing checks; slot 0 of the published bank is watched throughout.
  task automatic run_eval(input int ln, input bit t, input bit sp, input bit bg, input string tag);
    logic [31:0] pre;
    int moved = 0;
    @(negedge clk);
    rd_slot = '0; #1; pre = rd_entry;
    line = 9'(ln); tall = t; show_spr = sp; show_bg = bg; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R2", {tag, " busy after start"}, 32'(busy), 32'd1);
    chk("R2", {tag, " first addr"}, 32'(tab_addr), 32'd0);
    @(negedge clk);
    chk("R2", {tag, " second addr"}, 32'(tab_addr), 32'd1);
    for (int c = 2; c <= 64; c++) begin
      @(negedge clk);
      if (rd_entry !== pre) moved++;
    end
    chk("R2", {tag, " done early"}, 32'(done), 32'd0);
    chk("R9", {tag, " bank held during pass"}, 32'(moved), 32'd0);
    @(negedge clk);
    chk("R2", {tag, " done due"}, 32'(done), 32'd1);
    chk("R2", {tag, " busy low"}, 32'(busy), 32'd0);
    @(negedge clk);
    chk("R2", {tag, " done pulse"}, 32'(done), 32'd0);
    check_result(ln, t, sp | bg, tag);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    fill_empty();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int k = 0; k < 8; k++) begin
      rd_slot = 3'(k); #1;
      chk("R1", "reset slot", rd_entry, 32'hFFFF_FFFF);
    end
    chk("R1", "reset tags", 32'(slot_zero_tags), 32'd0);
    chk("R1", "reset flags", {29'd0, overflow, busy, done}, 32'd0);

    // R4 R6 basic: line 100, edges of the 8-line window
    fill_empty();
    tbl[0]  = mk(0, 8'd99);
    tbl[5]  = mk(5, 8'd95);
    tbl[10] = mk(10, 8'd101);
    tbl[20] = mk(20, 8'd93);
    tbl[21] = mk(21, 8'd92);
    run_eval(100, 1'b0, 1'b1, 1'b0, "R4 basic");

    // R7 overflow with ten qualifying, sprites enabled
    fill_empty();
    for (int j = 0; j < 10; j++) tbl[3 + 6*j] = mk(3 + 6*j, 8'd48);
    run_eval(50, 1'b0, 1'b1, 1'b0, "R7 ovf on");
    chk("R7", "overflow set", 32'(overflow), 32'd1);

    // R8 sticky across a pass with nothing qualifying, then cleared
    fill_empty();
    run_eval(50, 1'b0, 1'b0, 1'b0, "R8 sticky");
    chk("R8", "still set", 32'(overflow), 32'd1);
    pulse_clr();
    chk("R8", "cleared", 32'(overflow), 32'd0);

    // R7 gating: same crowd with displays off, then background only
    for (int j = 0; j < 10; j++) tbl[2 + 5*j] = mk(2 + 5*j, 8'd48);
    run_eval(50, 1'b0, 1'b0, 1'b0, "R7 ovf off");
    chk("R7", "no overflow when disabled", 32'(overflow), 32'd0);
    run_eval(50, 1'b0, 1'b0, 1'b1, "R7 bg only");
    chk("R7", "overflow with bg", 32'(overflow), 32'd1);
    pulse_clr();

    // R10 tall sprites
    fill_empty();
    tbl[0]  = mk(0, 8'd44);
    tbl[1]  = mk(1, 8'd45);
    tbl[9]  = mk(9, 8'd60);
    tbl[30] = mk(30, 8'd52);
    run_eval(60, 1'b1, 1'b1, 1'b1, "R10 tall");
    run_eval(60, 1'b0, 1'b1, 1'b1, "R10 short");

    // R4 bottom-of-screen cutoff
    fill_empty();
    tbl[4] = mk(4, 8'd239);
    tbl[7] = mk(7, 8'd240);
    tbl[8] = mk(8, 8'd255);
    tbl[12] = mk(12, 8'd233);
    run_eval(239, 1'b0, 1'b1, 1'b0, "R4 cutoff");
    run_eval(261, 1'b0, 1'b1, 1'b0, "R4 line261");

    // R11 restart mid-pass with a new table
    fill_empty();
    @(negedge clk); line = 9'd10; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    tbl[0] = mk(0, 8'd9);
    tbl[3] = mk(3, 8'd5);
    run_eval(10, 1'b0, 1'b1, 1'b0, "R11 restart");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule